// File: doc/BRIEF.md
# Trap Vector Capability Write Legalizer

This block sits beside the machine trap-vector capability register of a capability-extended RISC-V core. On every write it turns the value software supplies into a legal register value. Only direct vectoring is allowed, so the two lowest address bits are always cleared. Clearing them moves the address, so the block then repeats the set-address representability test on the moved address. It also rebuilds the cached base and top correction values so that later base and top queries decode correctly. A sealed capability, or one that stops being representable, is stored with its tag cleared. The write is never refused.

The legalized address and tag are also driven combinationally on `leg_addr_o` and `leg_tag_o`. These are the CSR write data, so the adjusted value, and not the raw source register, is what reaches the register. The held value is shown on the `rd_*` outputs, together with its decoded base and top. The write port has no back-pressure: a write strobe is accepted on the edge where it is high, every cycle.

The capability format is a compact one. It has a 4-bit exponent E and 9-bit base and top mantissas B and T. Each correction is coded 2'b00 for 0, 2'b01 for +1 and 2'b11 for -1. The representable boundary R is B minus 64, taken modulo 512. Let M be address bits [E+8:E]. The correction for a mantissa X is:
- +1 when M >= R and X < R;
- -1 when M < R and X >= R;
- 0 otherwise.

A bound decodes as ((address >> (E+9)) + correction) << (E+9), OR-ed with X << E, kept to 33 bits. The base output is the low 32 bits of this value.

Top module: `tvec_cap_legalizer`

## Requirements
- R1: The legalized address, both on `leg_addr_o` and as stored, has bits [1:0] equal to 00, and bits [31:2] equal to the written address.
- R2: On a rising edge with `wr_en_i` high, every stored field takes the legalized value. With `wr_en_i` low, every `rd_*` output keeps its value.
- R3: While `rst_ni` is low, the register holds address 0 with the tag clear. Exponent, mantissas, corrections and sealed flag are all zero.
- R4: A write whose sealed flag is set stores a cleared tag. The sealed flag is stored as written.
- R5: A write with its tag clear always stores a cleared tag.
- R6: The stored base and top corrections are recomputed from the legalized address using the rule and encoding above, whatever corrections came in.
- R7: `rd_base_o` and `rd_top_o` equal the decode of the stored address, exponent, mantissas and corrections.
- R8: The tag is cleared when the base or top decoded from the legalized address with the new corrections differs from the one decoded from the written address with the incoming corrections.
- R9: The tag is cleared when the legalized address lies below the base decoded from the written value. This covers a capability whose base equals an address with nonzero low bits.
- R10: A tagged, unsealed write that passes both checks keeps its tag and stores its exponent and mantissas unchanged.
- R11: `leg_addr_o` and `leg_tag_o` follow the current write inputs combinationally, and the next stored address and tag equal them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset |
| wr_en_i | input | 1 | CSR write strobe for this register |
| wr_addr_i | input | 32 | Address word being written |
| wr_tag_i | input | 1 | Incoming tag |
| wr_sealed_i | input | 1 | Incoming sealed flag |
| wr_exp_i | input | 4 | Incoming exponent E |
| wr_bmant_i | input | 9 | Incoming base mantissa |
| wr_tmant_i | input | 9 | Incoming top mantissa |
| wr_bcor_i | input | 2 | Incoming base correction |
| wr_tcor_i | input | 2 | Incoming top correction |
| leg_addr_o | output | 32 | Legalized address (CSR write data) |
| leg_tag_o | output | 1 | Legalized tag |
| rd_addr_o | output | 32 | Stored address |
| rd_tag_o | output | 1 | Stored tag |
| rd_sealed_o | output | 1 | Stored sealed flag |
| rd_exp_o | output | 4 | Stored exponent |
| rd_bmant_o | output | 9 | Stored base mantissa |
| rd_tmant_o | output | 9 | Stored top mantissa |
| rd_bcor_o | output | 2 | Stored base correction |
| rd_tcor_o | output | 2 | Stored top correction |
| rd_base_o | output | 32 | Decoded base of stored value |
| rd_top_o | output | 33 | Decoded top of stored value |

## Verification
Random writes cover every exponent, both low-bit states, both tag and seal states, and both enable states. Each random write is checked field by field against a bench model, so clearing, recomputation and hold behaviour are seen together. Directed cases handle the mutations that random data seldom reaches:
- an address whose M sits on R with low bits set, so clearing the low bits crosses the boundary and flips a correction;
- a base equal to an address ending in 01, so the cleared address falls below the base;
- a sealed but otherwise valid value, which separates the seal rule from the representability rule;
- a well-formed aligned write, which must keep its tag.

// File: rtl/tvec_pkg.sv
package tvec_pkg;
  localparam int unsigned ADDR_W = 32;
  localparam int unsigned EXP_W  = 4;
  localparam int unsigned MANT_W = 9;
  localparam int unsigned SH_W   = $clog2(ADDR_W) + 1;
  localparam int unsigned BND_W  = ADDR_W + 1;

  typedef enum logic [1:0] {
    COR_ZERO  = 2'b00,
    COR_PLUS  = 2'b01,
    COR_MINUS = 2'b11
  } cor_e;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic              tag;
    logic              sealed;
    logic [EXP_W-1:0]  exp;
    logic [MANT_W-1:0] bmant;
    logic [MANT_W-1:0] tmant;
    cor_e              bcor;
    cor_e              tcor;
  } tvec_cap_t;
endpackage

// File: rtl/tvec_corr_calc.sv
module tvec_corr_calc
  import tvec_pkg::*;
#(
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned EW = EXP_W,
  parameter int unsigned MW = MANT_W
) (
  input  logic [AW-1:0] addr_i,
  input  logic [EW-1:0] exp_i,
  input  logic [MW-1:0] bmant_i,
  input  logic [MW-1:0] mant_i,
  output cor_e          cor_o
);
  localparam logic [MW-1:0] EIGHTH = MW'(1) << (MW - 3);

  logic [MW-1:0] mid;
  logic [MW-1:0] rbound;
  logic          mid_low;
  logic          mant_low;

  always_comb begin
    mid      = MW'(addr_i >> exp_i);
    rbound   = bmant_i - EIGHTH;
    mid_low  = mid < rbound;
    mant_low = mant_i < rbound;
    if (mid_low == mant_low)      cor_o = COR_ZERO;
    else if (mid_low)             cor_o = COR_MINUS;
    else                          cor_o = COR_PLUS;
  end
endmodule

// File: rtl/tvec_bound_decode.sv
module tvec_bound_decode
  import tvec_pkg::*;
#(
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned EW = EXP_W,
  parameter int unsigned MW = MANT_W
) (
  input  logic [AW-1:0] addr_i,
  input  logic [EW-1:0] exp_i,
  input  logic [MW-1:0] mant_i,
  input  cor_e          cor_i,
  output logic [AW:0]   bound_o
);
  localparam int unsigned VW = AW + 2;
  localparam int unsigned SW = $clog2(AW) + 1;

  logic [SW-1:0] shamt;
  logic [VW-1:0] upper;
  logic [VW-1:0] cor_ext;
  logic [VW-1:0] value;

  always_comb begin
    shamt   = SW'(exp_i) + SW'(MW);
    upper   = VW'(addr_i) >> shamt;
    cor_ext = {{(VW-2){cor_i[1]}}, cor_i};
    value   = ((upper + cor_ext) << shamt) | (VW'(mant_i) << exp_i);
    bound_o = value[AW:0];
  end
endmodule

// File: rtl/tvec_legalize.sv
module tvec_legalize
  import tvec_pkg::*;
(
  input  tvec_cap_t wr_cap_i,
  output tvec_cap_t leg_cap_o
);
  // index 0: base side, index 1: top side
  logic [MANT_W-1:0] side_mant [2];
  cor_e              old_cor   [2];
  cor_e              new_cor   [2];
  logic [BND_W-1:0]  old_bnd   [2];
  logic [BND_W-1:0]  new_bnd   [2];
  logic [ADDR_W-1:0] adj_addr;
  logic              rep_ok;

  assign adj_addr     = {wr_cap_i.addr[ADDR_W-1:2], 2'b00};
  assign side_mant[0] = wr_cap_i.bmant;
  assign side_mant[1] = wr_cap_i.tmant;
  assign old_cor[0]   = wr_cap_i.bcor;
  assign old_cor[1]   = wr_cap_i.tcor;

  for (genvar s = 0; s < 2; s++) begin : g_side
    tvec_corr_calc u_cor (
      .addr_i  (adj_addr),
      .exp_i   (wr_cap_i.exp),
      .bmant_i (wr_cap_i.bmant),
      .mant_i  (side_mant[s]),
      .cor_o   (new_cor[s])
    );
    tvec_bound_decode u_old (
      .addr_i  (wr_cap_i.addr),
      .exp_i   (wr_cap_i.exp),
      .mant_i  (side_mant[s]),
      .cor_i   (old_cor[s]),
      .bound_o (old_bnd[s])
    );
    tvec_bound_decode u_new (
      .addr_i  (adj_addr),
      .exp_i   (wr_cap_i.exp),
      .mant_i  (side_mant[s]),
      .cor_i   (new_cor[s]),
      .bound_o (new_bnd[s])
    );
  end

  always_comb begin
    rep_ok = (old_bnd[0] == new_bnd[0]) &&
             (old_bnd[1] == new_bnd[1]) &&
             ({1'b0, adj_addr} >= old_bnd[0]);
    leg_cap_o      = wr_cap_i;
    leg_cap_o.addr = adj_addr;
    leg_cap_o.bcor = new_cor[0];
    leg_cap_o.tcor = new_cor[1];
    leg_cap_o.tag  = wr_cap_i.tag & ~wr_cap_i.sealed & rep_ok;
  end
endmodule

// File: rtl/tvec_cap_legalizer.sv
module tvec_cap_legalizer
  import tvec_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [ADDR_W-1:0]  wr_addr_i,
  input  logic               wr_tag_i,
  input  logic               wr_sealed_i,
  input  logic [EXP_W-1:0]   wr_exp_i,
  input  logic [MANT_W-1:0]  wr_bmant_i,
  input  logic [MANT_W-1:0]  wr_tmant_i,
  input  logic [1:0]         wr_bcor_i,
  input  logic [1:0]         wr_tcor_i,
  output logic [ADDR_W-1:0]  leg_addr_o,
  output logic               leg_tag_o,
  output logic [ADDR_W-1:0]  rd_addr_o,
  output logic               rd_tag_o,
  output logic               rd_sealed_o,
  output logic [EXP_W-1:0]   rd_exp_o,
  output logic [MANT_W-1:0]  rd_bmant_o,
  output logic [MANT_W-1:0]  rd_tmant_o,
  output logic [1:0]         rd_bcor_o,
  output logic [1:0]         rd_tcor_o,
  output logic [ADDR_W-1:0]  rd_base_o,
  output logic [ADDR_W:0]    rd_top_o
);
  tvec_cap_t wr_cap;
  tvec_cap_t leg_cap;
  tvec_cap_t cap_q;
  logic [BND_W-1:0] rd_bnd [2];
  logic [MANT_W-1:0] rd_mant [2];
  cor_e rd_cor [2];

  always_comb begin
    wr_cap.addr   = wr_addr_i;
    wr_cap.tag    = wr_tag_i;
    wr_cap.sealed = wr_sealed_i;
    wr_cap.exp    = wr_exp_i;
    wr_cap.bmant  = wr_bmant_i;
    wr_cap.tmant  = wr_tmant_i;
    wr_cap.bcor   = cor_e'(wr_bcor_i);
    wr_cap.tcor   = cor_e'(wr_tcor_i);
  end

  tvec_legalize u_leg (
    .wr_cap_i  (wr_cap),
    .leg_cap_o (leg_cap)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_q <= '{addr: '0, tag: 1'b0, sealed: 1'b0, exp: '0,
                 bmant: '0, tmant: '0, bcor: COR_ZERO, tcor: COR_ZERO};
    end else if (wr_en_i) begin
      cap_q <= leg_cap;
    end
  end

  assign rd_mant[0] = cap_q.bmant;
  assign rd_mant[1] = cap_q.tmant;
  assign rd_cor[0]  = cap_q.bcor;
  assign rd_cor[1]  = cap_q.tcor;

  for (genvar s = 0; s < 2; s++) begin : g_rd
    tvec_bound_decode u_dec (
      .addr_i  (cap_q.addr),
      .exp_i   (cap_q.exp),
      .mant_i  (rd_mant[s]),
      .cor_i   (rd_cor[s]),
      .bound_o (rd_bnd[s])
    );
  end

  assign leg_addr_o  = leg_cap.addr;
  assign leg_tag_o   = leg_cap.tag;
  assign rd_addr_o   = cap_q.addr;
  assign rd_tag_o    = cap_q.tag;
  assign rd_sealed_o = cap_q.sealed;
  assign rd_exp_o    = cap_q.exp;
  assign rd_bmant_o  = cap_q.bmant;
  assign rd_tmant_o  = cap_q.tmant;
  assign rd_bcor_o   = cap_q.bcor;
  assign rd_tcor_o   = cap_q.tcor;
  assign rd_base_o   = rd_bnd[0][ADDR_W-1:0];
  assign rd_top_o    = rd_bnd[1];
endmodule

// File: rtl/tvec_legalizer_chk.sv
module tvec_legalizer_chk
  import tvec_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic               wr_en_i,
  input logic [ADDR_W-1:0]  wr_addr_i,
  input logic               wr_tag_i,
  input logic               wr_sealed_i,
  input logic [ADDR_W-1:0]  leg_addr_o,
  input logic               leg_tag_o,
  input logic [ADDR_W-1:0]  rd_addr_o,
  input logic               rd_tag_o,
  input logic               rd_sealed_o,
  input logic [ADDR_W-1:0]  rd_base_o
);
  AST_LOW_BITS_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_addr_o[1:0] == 2'b00); // R1
  AST_UPPER_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> rd_addr_o[ADDR_W-1:2] == $past(wr_addr_i[ADDR_W-1:2])); // R1
  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(rd_addr_o) && $stable(rd_tag_o) && $stable(rd_sealed_o)); // R2
  AST_SEALED_UNTAGGED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && wr_sealed_i |=> !rd_tag_o); // R4
  AST_NO_TAG_GAIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && !wr_tag_i |=> !rd_tag_o); // R5
  AST_TAGGED_ABOVE_BASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_tag_o |-> rd_addr_o >= rd_base_o); // R9
  AST_WDATA_STORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> rd_addr_o == $past(leg_addr_o) && rd_tag_o == $past(leg_tag_o)); // R11
endmodule

bind tvec_cap_legalizer tvec_legalizer_chk u_chk (.*);

// File: tb/tb_tvec_cap_legalizer.sv
module tb_tvec_cap_legalizer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [31:0] wr_addr = '0;
  logic wr_tag = 1'b0, wr_sealed = 1'b0;
  logic [3:0] wr_exp = '0;
  logic [8:0] wr_bm = '0, wr_tm = '0;
  logic [1:0] wr_bc = '0, wr_tc = '0;
  logic [31:0] leg_addr, rd_addr, rd_base;
  logic leg_tag, rd_tag, rd_sealed;
  logic [3:0] rd_exp;
  logic [8:0] rd_bm, rd_tm;
  logic [1:0] rd_bc, rd_tc;
  logic [32:0] rd_top;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // expected stored state
  logic [31:0] e_addr; logic e_tag, e_sealed; logic [3:0] e_exp;
  logic [8:0] e_bm, e_tm; logic [1:0] e_bc, e_tc;

  always #4 clk = ~clk;

  tvec_cap_legalizer dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_tag_i(wr_tag), .wr_sealed_i(wr_sealed), .wr_exp_i(wr_exp),
    .wr_bmant_i(wr_bm), .wr_tmant_i(wr_tm), .wr_bcor_i(wr_bc), .wr_tcor_i(wr_tc),
    .leg_addr_o(leg_addr), .leg_tag_o(leg_tag), .rd_addr_o(rd_addr),
    .rd_tag_o(rd_tag), .rd_sealed_o(rd_sealed), .rd_exp_o(rd_exp),
    .rd_bmant_o(rd_bm), .rd_tmant_o(rd_tm), .rd_bcor_o(rd_bc), .rd_tcor_o(rd_tc),
    .rd_base_o(rd_base), .rd_top_o(rd_top)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // correction per the requirement rule: 0=00, +1=01, -1=11
  function automatic logic [1:0] m_cor(input logic [31:0] a, input int e,
                                       input logic [8:0] b, input logic [8:0] x);
    logic [8:0] m, r;
    m = 9'((a >> e) & 32'h1ff);
    r = b - 9'd64;
    if ((m >= r) && (x < r)) return 2'b01;
    if ((m < r) && (x >= r)) return 2'b11;
    return 2'b00;
  endfunction

  function automatic logic [32:0] m_dec(input logic [31:0] a, input int e,
                                        input logic [8:0] x, input logic [1:0] c);
    longint up, cv, v;
    up = longint'(a) >>> (e + 9);
    cv = (c == 2'b01) ? 1 : (c == 2'b11) ? -1 : 0;
    v  = ((up + cv) << (e + 9)) | (longint'(x) << e);
    return v[32:0];
  endfunction

  task automatic do_write(input logic en, input logic [31:0] a, input logic tg,
                          input logic sl, input logic [3:0] e, input logic [8:0] b,
                          input logic [8:0] t, input logic [1:0] bc, input logic [1:0] tc,
                          input string tagname);
    logic [31:0] na; logic [1:0] nbc, ntc; logic ntag, rep;
    @(negedge clk);
    wr_en = en; wr_addr = a; wr_tag = tg; wr_sealed = sl; wr_exp = e;
    wr_bm = b; wr_tm = t; wr_bc = bc; wr_tc = tc;
    na  = {a[31:2], 2'b00};
    nbc = m_cor(na, int'(e), b, b);
    ntc = m_cor(na, int'(e), b, t);
    // R8 and R9: unchanged bounds and address not below base
    rep = (m_dec(a, int'(e), b, bc) == m_dec(na, int'(e), b, nbc)) &&
          (m_dec(a, int'(e), t, tc) == m_dec(na, int'(e), t, ntc)) &&
          ({1'b0, na} >= m_dec(a, int'(e), b, bc));
    ntag = tg & ~sl & rep;
    #1;
    chk(leg_addr == na, {"R11/R1 leg_addr ", tagname}, 64'(leg_addr), 64'(na));
    chk(leg_tag == ntag, {"R11 leg_tag ", tagname}, 64'(leg_tag), 64'(ntag));
    if (en) begin
      e_addr = na; e_tag = ntag; e_sealed = sl; e_exp = e;
      e_bm = b; e_tm = t; e_bc = nbc; e_tc = ntc;
    end
    @(posedge clk); #2;
    chk(rd_addr == e_addr, {"R1/R2 rd_addr ", tagname}, 64'(rd_addr), 64'(e_addr));
    chk(rd_tag == e_tag, {"R4/R5/R8/R9/R10 rd_tag ", tagname}, 64'(rd_tag), 64'(e_tag));
    chk({rd_sealed, rd_exp, rd_bm, rd_tm} == {e_sealed, e_exp, e_bm, e_tm},
        {"R2/R10 fields ", tagname}, 64'({rd_sealed, rd_exp, rd_bm, rd_tm}),
        64'({e_sealed, e_exp, e_bm, e_tm}));
    chk({rd_bc, rd_tc} == {e_bc, e_tc}, {"R6 corrections ", tagname},
        64'({rd_bc, rd_tc}), 64'({e_bc, e_tc}));
    chk({1'b0, rd_base} == m_dec(e_addr, int'(e_exp), e_bm, e_bc), {"R7 base ", tagname},
        64'(rd_base), 64'(m_dec(e_addr, int'(e_exp), e_bm, e_bc)));
    chk(rd_top == m_dec(e_addr, int'(e_exp), e_tm, e_tc), {"R7 top ", tagname},
        64'(rd_top), 64'(m_dec(e_addr, int'(e_exp), e_tm, e_tc)));
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    wr_addr = 32'hffff_ffff; wr_tag = 1'b1; wr_exp = 4'd5; wr_bm = 9'h1ff;
    repeat (3) @(posedge clk);
    #2;
    // R3: reset value
    chk(rd_addr == 32'd0 && !rd_tag, "R3 reset addr/tag", 64'({rd_addr, rd_tag}), 64'd0);
    chk({rd_sealed, rd_exp, rd_bm, rd_tm, rd_bc, rd_tc} == '0, "R3 reset fields",
        64'({rd_sealed, rd_exp, rd_bm, rd_tm, rd_bc, rd_tc}), 64'd0);
    e_addr = '0; e_tag = 0; e_sealed = 0; e_exp = '0; e_bm = '0; e_tm = '0; e_bc = '0; e_tc = '0;
    @(negedge clk); rst_n = 1'b1;

    // R10: clean aligned write keeps tag
    do_write(1, 32'h0000_1234, 1, 0, 4'd0, 9'h030, 9'h0f0,
             m_cor(32'h1234, 0, 9'h030, 9'h030), m_cor(32'h1234, 0, 9'h030, 9'h0f0), "R10 aligned");
    // R2: idle write ignored
    do_write(0, 32'habcd_ef03, 0, 1, 4'd3, 9'h011, 9'h022, 2'b01, 2'b11, "R2 idle");
    // R8: low bits cross boundary R=6 with base mant 0x46
    do_write(1, 32'h0000_0206, 1, 0, 4'd0, 9'h046, 9'h0a0,
             m_cor(32'h206, 0, 9'h046, 9'h046), m_cor(32'h206, 0, 9'h046, 9'h0a0), "R8 cross");
    // R9: base equals address with low bits 01
    do_write(1, 32'h0000_0485, 1, 0, 4'd0, 9'h085, 9'h100,
             m_cor(32'h485, 0, 9'h085, 9'h085), m_cor(32'h485, 0, 9'h085, 9'h100), "R9 below base");
    // R4: sealed but otherwise valid
    do_write(1, 32'h0000_1234, 1, 1, 4'd0, 9'h030, 9'h0f0,
             m_cor(32'h1234, 0, 9'h030, 9'h030), m_cor(32'h1234, 0, 9'h030, 9'h0f0), "R4 sealed");
    // R5: untagged valid
    do_write(1, 32'h0000_5678, 0, 0, 4'd2, 9'h040, 9'h1f0,
             m_cor(32'h5678, 2, 9'h040, 9'h040), m_cor(32'h5678, 2, 9'h040, 9'h1f0), "R5 untagged");
    // R6: deliberately wrong incoming corrections are replaced
    do_write(1, 32'h0000_1234, 0, 0, 4'd0, 9'h030, 9'h0f0, 2'b11, 2'b01, "R6 stale cor");

    for (int i = 0; i < 400; i++) begin
      logic [31:0] a; logic [3:0] e; logic [8:0] b, t; logic [1:0] bc, tc;
      a = $urandom; e = 4'($urandom % 16); b = 9'($urandom); t = 9'($urandom);
      if ($urandom % 3 == 0) a[1:0] = 2'b00;
      bc = m_cor(a, int'(e), b, b); tc = m_cor(a, int'(e), b, t);
      do_write(($urandom % 5) != 0, a, 1'($urandom % 4 != 0), 1'($urandom % 4 == 0),
               e, b, t, bc, tc, "random");
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule